// File: doc/BRIEF.md
# Self-Timed Flash Operation Controller

This block sits between a programming front end and a non-volatile memory array. It holds a 16-bit control word that software writes through a simple register port. Bit 15 of the word is the start bit and the lower fifteen bits hold an operation code. When a word is written with the start bit set, the controller decodes the code and raises the erase enables for the matching memory regions. It then counts a delay that depends on the class of the operation. When the delay ends, the controller clears the start bit without any help from software.

Software watches the start bit, or the busy output, to learn when the array is free again. The controller ignores writes while an operation is running. A code it does not recognise never reaches the array: the controller flags the code, drops the start bit in the same cycle and leaves the enables low. The delay of each class is a parameter. A bulk erase must take the longest delay and a single configuration byte the shortest.

Top module: `nvm_op_ctrl`

## Requirements
- R1: After reset, rd_data is 0x0000, and busy, done, err and every erase_en bit are 0.
- R2: A write while idle with bit 15 clear stores the full word in the register and starts nothing: busy and erase_en stay 0.
- R3: Writing 0xC04F (start set, code 0x404F) raises erase_en bits 0 (all code memory), 1 (executive memory) and 2 (all configuration registers), and no other bits, for T_BULK cycles.
- R4: Writing 0xC04D raises erase_en bits 3 (general segment) and 4 (general segment configuration), and no other bits, for T_SEG cycles.
- R5: Writing 0xC04C raises erase_en bits 5 (secure segment) and 6 (secure configuration). It also raises bits 3 and 4, and it runs for T_SEG cycles.
- R6: Writing 0xC042 raises only erase_en bit 7 (one page) for T_PAGE cycles. Writing 0xC040 raises only bit 8 (one configuration byte) for T_CFGB cycles.
- R7: After a valid start, rd_data[15] and busy read 1 for exactly the delay of the operation's class. Bit 15 then clears, while rd_data[14:0] keeps the written code.
- R8: done is high for exactly one cycle, in the first cycle after the start bit clears.
- R9: A write while busy is ignored. rd_data, erase_en and the duration of the operation are unchanged.
- R10: A write while idle with bit 15 set and an unlisted code sets err. It stores the word with bit 15 cleared and raises neither busy, done nor any erase_en bit. err then follows the next write accepted while idle, and a valid start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control register contents |
| busy | output | 1 | Operation in progress (mirror of bit 15) |
| done | output | 1 | One-cycle pulse when an operation completes |
| err | output | 1 | Last accepted start carried an unlisted code |
| erase_en | output | 9 | Region erase enables, held for the operation |

## Verification
Each of the five listed codes is started once. The region mask shows that decode routes each code correctly, and the measured busy length shows that each class selects its own delay. The secure-segment code also proves that the general-segment bits come with it. A write of the bulk code during a page erase separates a controller that really ignores busy writes from one that restarts or merges them. Writes with no start bit, and an unlisted code followed by a valid start, set the stored-only path and the error path apart from a real launch.

// File: rtl/nvm_op_pkg.sv
package nvm_op_pkg;
   localparam int unsigned REG_W     = 16;
   localparam int unsigned START_BIT = 15;
   localparam int unsigned CODE_W    = 15;
   localparam int unsigned N_REGION  = 9;

   // region enable positions
   localparam int unsigned RG_CODE_ALL = 0;
   localparam int unsigned RG_EXEC     = 1;
   localparam int unsigned RG_CFG_ALL  = 2;
   localparam int unsigned RG_GEN_SEG  = 3;
   localparam int unsigned RG_GEN_CFG  = 4;
   localparam int unsigned RG_SEC_SEG  = 5;
   localparam int unsigned RG_SEC_CFG  = 6;
   localparam int unsigned RG_PAGE     = 7;
   localparam int unsigned RG_CFG_BYTE = 8;

   // operation codes (start bit excluded)
   localparam logic [CODE_W-1:0] OP_BULK     = 15'h404F;
   localparam logic [CODE_W-1:0] OP_GEN      = 15'h404D;
   localparam logic [CODE_W-1:0] OP_SEC      = 15'h404C;
   localparam logic [CODE_W-1:0] OP_PAGE     = 15'h4042;
   localparam logic [CODE_W-1:0] OP_CFG_BYTE = 15'h4040;

   typedef enum logic [2:0] {
      CLS_NONE, CLS_BULK, CLS_SEG, CLS_PAGE, CLS_BYTE
   } op_class_e;

   typedef struct packed {
      logic                valid;
      op_class_e           cls;
      logic [N_REGION-1:0] regions;
   } op_decode_t;
endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
   import nvm_op_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output op_decode_t        dec
);
   always_comb begin
      dec = '{valid: 1'b0, cls: CLS_NONE, regions: '0};
      unique case (code)
         OP_BULK: begin
            dec.valid = 1'b1;
            dec.cls   = CLS_BULK;
            dec.regions[RG_CODE_ALL] = 1'b1;
            dec.regions[RG_EXEC]     = 1'b1;
            dec.regions[RG_CFG_ALL]  = 1'b1;
         end
         OP_GEN, OP_SEC: begin
            dec.valid = 1'b1;
            dec.cls   = CLS_SEG;
            dec.regions[RG_GEN_SEG] = 1'b1;
            dec.regions[RG_GEN_CFG] = 1'b1;
            if (code == OP_SEC) begin
               dec.regions[RG_SEC_SEG] = 1'b1;
               dec.regions[RG_SEC_CFG] = 1'b1;
            end
         end
         OP_PAGE: begin
            dec.valid = 1'b1;
            dec.cls   = CLS_PAGE;
            dec.regions[RG_PAGE] = 1'b1;
         end
         OP_CFG_BYTE: begin
            dec.valid = 1'b1;
            dec.cls   = CLS_BYTE;
            dec.regions[RG_CFG_BYTE] = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer
   import nvm_op_pkg::*;
#(
   parameter int unsigned T_BULK = 40,
   parameter int unsigned T_SEG  = 24,
   parameter int unsigned T_PAGE = 12,
   parameter int unsigned T_CFGB = 6,
   localparam int unsigned CNT_W = $clog2(T_BULK) + 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  op_class_e cls,
   output logic      zero
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   always_comb begin
      unique case (cls)
         CLS_BULK: reload = CNT_W'(T_BULK - 1);
         CLS_SEG:  reload = CNT_W'(T_SEG - 1);
         CLS_PAGE: reload = CNT_W'(T_PAGE - 1);
         CLS_BYTE: reload = CNT_W'(T_CFGB - 1);
         default:  reload = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= reload;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvm_op_ctrl.sv
module nvm_op_ctrl
   import nvm_op_pkg::*;
#(
   parameter int unsigned T_BULK = 40,
   parameter int unsigned T_SEG  = 24,
   parameter int unsigned T_PAGE = 12,
   parameter int unsigned T_CFGB = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [N_REGION-1:0] erase_en
);
   // elaboration-time parameter checks
   if (T_CFGB < 1) begin : g_bad_cfgb
      $error("T_CFGB must be at least 1");
   end
   if (!(T_BULK > T_PAGE && T_BULK >= T_SEG && T_SEG >= T_PAGE && T_PAGE >= T_CFGB)) begin : g_bad_order
      $error("delays must satisfy T_BULK > T_PAGE, T_BULK >= T_SEG >= T_PAGE >= T_CFGB");
   end

   logic [REG_W-1:0]    ctrl_q;
   logic [N_REGION-1:0] region_q;
   logic                err_q, done_q;
   op_decode_t          dec;
   logic                accept, start_ok, finish, tmr_zero;

   nvm_op_decode u_dec (
      .code (wr_data[CODE_W-1:0]),
      .dec  (dec)
   );

   assign accept   = wr_en && !ctrl_q[START_BIT];
   assign start_ok = accept && wr_data[START_BIT] && dec.valid;

   nvm_op_timer #(
      .T_BULK (T_BULK), .T_SEG (T_SEG), .T_PAGE (T_PAGE), .T_CFGB (T_CFGB)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_ok),
      .cls   (dec.cls),
      .zero  (tmr_zero)
   );

   assign finish = ctrl_q[START_BIT] && tmr_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         region_q <= '0;
         err_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            ctrl_q   <= {start_ok, wr_data[CODE_W-1:0]};
            err_q    <= wr_data[START_BIT] && !dec.valid;
            region_q <= start_ok ? dec.regions : '0;
         end else if (finish) begin
            ctrl_q[START_BIT] <= 1'b0;
            region_q          <= '0;
         end
      end
   end

   // gate each region enable with the live start bit
   for (genvar i = 0; i < N_REGION; i++) begin : g_region
      assign erase_en[i] = region_q[i] & ctrl_q[START_BIT];
   end

   assign rd_data = ctrl_q;
   assign busy    = ctrl_q[START_BIT];
   assign done    = done_q;
   assign err     = err_q;
endmodule

// File: rtl/nvm_op_ctrl_chk.sv
module nvm_op_ctrl_chk
   import nvm_op_pkg::*;
#(
   parameter int unsigned T_BULK = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [REG_W-1:0]    rd_data,
   input logic                busy,
   input logic                done,
   input logic                err,
   input logic [N_REGION-1:0] erase_en
);
   int unsigned busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R7
   busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < T_BULK));
   // R3
   region_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (erase_en == '0));
   // R3
   region_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(erase_en));
   // R9
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> (rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0])));
   // R10
   err_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && erase_en == '0));
   // R5
   sec_implies_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en[RG_SEC_SEG] |-> (erase_en[RG_GEN_SEG] && erase_en[RG_GEN_CFG]));
   // R6
   page_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_en[RG_PAGE] || erase_en[RG_CFG_BYTE]) |-> ($countones(erase_en) == 1));
endmodule

bind nvm_op_ctrl nvm_op_ctrl_chk #(.T_BULK(T_BULK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_data  (rd_data),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .erase_en (erase_en)
);

// File: tb/nvm_op_ctrl_tb.sv
module nvm_op_ctrl_tb;
   localparam int T_BULK = 40;
   localparam int T_SEG  = 24;
   localparam int T_PAGE = 12;
   localparam int T_CFGB = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        busy, done, err;
   logic [8:0]  erase_en;

   always #5 clk = ~clk;

   nvm_op_ctrl #(.T_BULK(T_BULK), .T_SEG(T_SEG), .T_PAGE(T_PAGE), .T_CFGB(T_CFGB)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .busy(busy), .done(done), .err(err), .erase_en(erase_en)
   );

   typedef struct {
      logic [15:0] word;
      logic [8:0]  regions;
      int          cycles;
      logic        is_err;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   mon_go = 0;
   bit   mon_done = 0;
   bit   finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // driver: pushes the expectation, then writes the word
   task automatic do_op(input logic [15:0] word, input logic [8:0] regions,
                        input int cycles, input logic is_err, input string tag,
                        input bit intrude);
      exp_t e;
      e.word = word; e.regions = regions; e.cycles = cycles; e.is_err = is_err; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      wr_en = 1'b1; wr_data = word;
      mon_done = 0; mon_go = 1;
      @(negedge clk);
      wr_en = 1'b0;
      if (intrude) begin
         repeat (2) @(negedge clk);
         wr_en = 1'b1; wr_data = 16'hC04F;   // R9 write while busy
         @(negedge clk);
         wr_en = 1'b0;
      end
      wait (mon_done);
   endtask

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         exp_t e;
         int   n;
         bit   bad_rd, bad_rg;
         wait (mon_go);
         mon_go = 0;
         e = exp_q.pop_front();
         @(negedge clk);
         if (e.is_err) begin
            chk(err == 1'b1, {e.tag, " R10 err set"}, err, 1);
            chk(busy == 1'b0 && erase_en == '0, {e.tag, " R10 no op"}, {busy, erase_en}, 0);
            chk(rd_data == (e.word & 16'h7FFF), {e.tag, " R10 stored"}, rd_data, e.word & 16'h7FFF);
            @(negedge clk);
            chk(done == 1'b0, {e.tag, " R10 no done"}, done, 0);
         end else begin
            n = 0; bad_rd = 0; bad_rg = 0;
            chk(err == 1'b0, {e.tag, " R10 err clear"}, err, 0);
            while (busy && n < 200) begin
               if (rd_data != e.word)       bad_rd = 1;
               if (erase_en != e.regions)   bad_rg = 1;
               n++;
               @(negedge clk);
            end
            chk(!bad_rg, {e.tag, " regions"}, erase_en, e.regions);
            chk(!bad_rd, {e.tag, " R9 R7 rd held"}, rd_data, e.word);
            chk(n == e.cycles, {e.tag, " R7 busy length"}, n, e.cycles);
            chk(done == 1'b1, {e.tag, " R8 done rises"}, done, 1);
            chk(rd_data == (e.word & 16'h7FFF), {e.tag, " R7 start cleared"}, rd_data, e.word & 16'h7FFF);
            chk(erase_en == '0, {e.tag, " R3 regions off"}, erase_en, 0);
            @(negedge clk);
            chk(done == 1'b0, {e.tag, " R8 done one cycle"}, done, 0);
         end
         mon_done = 1;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data == 16'h0000, "R1 rd_data", rd_data, 0);
      chk(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
      chk(erase_en == '0, "R1 erase_en", erase_en, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 write without start bit
      wr_en = 1'b1; wr_data = 16'h404F;
      @(negedge clk);
      wr_en = 1'b0;
      chk(rd_data == 16'h404F, "R2 stored", rd_data, 16'h404F);
      chk(busy == 0 && erase_en == '0, "R2 no op", {busy, erase_en}, 0);
      @(negedge clk);
      chk(busy == 0 && done == 0, "R2 still idle", {busy, done}, 0);

      do_op(16'hC04F, 9'b000000111, T_BULK, 1'b0, "R3 bulk", 1'b0);
      do_op(16'hC04D, 9'b000011000, T_SEG,  1'b0, "R4 general", 1'b0);
      do_op(16'hC04C, 9'b001111000, T_SEG,  1'b0, "R5 secure", 1'b0);
      do_op(16'hC042, 9'b010000000, T_PAGE, 1'b0, "R6 page", 1'b0);
      do_op(16'hC040, 9'b100000000, T_CFGB, 1'b0, "R6 cfg byte", 1'b0);
      do_op(16'hC042, 9'b010000000, T_PAGE, 1'b0, "R9 page with busy write", 1'b1);
      do_op(16'hC041, 9'b000000000, 0,      1'b1, "R10 unlisted", 1'b0);
      do_op(16'h8000, 9'b000000000, 0,      1'b1, "R10 zero code", 1'b0);
      do_op(16'hC040, 9'b100000000, T_CFGB, 1'b0, "R10 recover", 1'b0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule